// File: doc/BRIEF.md
# OTP Secure-Area Access Filter

This block stands between a bus requester and a byte-wide one-time programmable array. Every read or program request passes through it. For addresses in the secure area it decides whether the access may reach the array. The decision uses four protection bytes that are captured from the array after reset. These bytes carry active-low read-lock and write-lock bits for each stored key, and world gating for the two user-defined windows. An unprogrammed bit reads as 1, which means "open". Programming a bit to 0 closes the matching path, and that step cannot be undone.

The array read port is combinational, so the filter takes one request per cycle and answers in the next cycle. A refused read returns 0xFF and raises an error pulse. A refused write never reaches the array and raises the same pulse. A granted write does not send the raw data. It sends the old byte ANDed with the new data, so a stored bit can go from 1 to 0 but never from 0 to 1. A write to one of the protection bytes is always granted. The captured copy takes the stored result at the same clock edge, so the next request is judged under the tighter policy.

Top module: `otp_key_guard`

## Requirements
- R1: After reset is released, the block uses four consecutive cycles to read bytes 0x364, 0x365, 0x366 and 0x367 in that order on `arr_addr_o`, with no array write in those cycles. Every request made before this load is complete is refused.
- R2: The eight 32-byte keys start at 0x200 + 32·k for k = 0..7. Taking the protection bytes as one 32-bit word with 0x364 as bits 7:0, key k is read-locked by bit 11+2k and write-locked by bit 12+2k. A lock is in force when its bit is 0. A read of a read-locked key returns 0xFF with `err_o`. A read of an unlocked key returns the array byte.
- R3: A write to a write-locked region does not assert `arr_we_o`, leaves the array unchanged and gives `err_o` in the response cycle.
- R4: The 16-byte debug password at 0x300 is read-locked by word bit 5 and write-locked by bit 6. The 16-byte unique key at 0x310 is write-locked by bit 7. The 32-byte hashes at 0x320 and 0x340 are write-locked by bits 9 and 10. These three regions have no read lock.
- R5: User window 1 (0x380–0x3BF) is gated by word bit 30 and window 2 (0x3C0–0x3FF) by bit 31. When the gate bit is 0, a request with `secure_i` low is refused and a request with `secure_i` high proceeds. When the gate bit is 1, both worlds proceed.
- R6: A granted write drives `arr_wdata_o` equal to the current array byte ANDed with `wdata_i`, so no stored bit is ever set.
- R7: Writes to 0x364–0x367 are always granted. The captured copy takes the stored byte at the same edge, and the request in the very next cycle sees the new locks.
- R8: For each request, `rsp_valid_o` pulses exactly one cycle later. `err_o` is asserted only together with `rsp_valid_o`. `rsp_rdata_o` carries the array byte only for a granted read and is 0xFF otherwise.
- R9: Once the load is complete, requests below 0x200 and to the non-key bytes 0x360–0x37F are never refused.
- R10: A lock that is at 0 cannot be reopened. A later write of 0xFF to its protection byte leaves it in force, and this still holds after a new reset and reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request valid this cycle |
| we_i | input | 1 | 1 = program request, 0 = read request |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 8 | Program data |
| secure_i | input | 1 | Request comes from the secure world |
| rsp_valid_o | output | 1 | Response to the previous cycle's request |
| rsp_rdata_o | output | 8 | Read data, 0xFF when refused or for writes |
| err_o | output | 1 | Previous request was refused |
| arr_addr_o | output | ADDR_W | Array address (loader address during boot) |
| arr_rdata_i | input | 8 | Combinational array read data |
| arr_we_o | output | 1 | Array program strobe |
| arr_wdata_o | output | 8 | Masked byte to program |

## Verification
Two functions fall in the same cycle. A write to a protection byte both programs the array through the 1-to-0 mask and tightens the captured policy, so the request in the very next cycle is the first one judged under the new locks. The bench provokes this by clearing a lock bit and then, one cycle later, reading or writing the region that bit guards. It also provokes the overlap between the last boot-load cycle and the first request. A behavioural reference model, with its own memory image and its own copy of the lock word, judges the strobe and masked data in the request cycle and the response in the following cycle.

// File: rtl/otp_guard_pkg.sv
package otp_guard_pkg;
  typedef logic [7:0] byte_t;

  localparam int NUM_KEYS   = 12;
  localparam int NUM_UAREAS = 2;
  localparam int CFG_BYTES  = 4;
  localparam int CFG_BITS   = CFG_BYTES * 8;
  localparam int CFG_BASE   = 'h364;
  localparam int SEC_BASE   = 'h200;
  localparam int UA_BASE    = 'h380;
  localparam int UA_LEN     = 64;
  localparam int NO_BIT     = -1;

  // regions 0..7: 32-byte keys, 8: debug password, 9: unique key, 10/11: hashes
  function automatic int key_base(int k);
    if (k < 8)       return 'h200 + 32 * k;
    else if (k == 8) return 'h300;
    else if (k == 9) return 'h310;
    else if (k == 10) return 'h320;
    else             return 'h340;
  endfunction

  function automatic int key_len(int k);
    return (k == 8 || k == 9) ? 16 : 32;
  endfunction

  function automatic int key_rd_bit(int k);
    if (k < 8)       return 11 + 2 * k;
    else if (k == 8) return 5;
    else             return NO_BIT;
  endfunction

  function automatic int key_wr_bit(int k);
    if (k < 8)        return 12 + 2 * k;
    else if (k == 8)  return 6;
    else if (k == 9)  return 7;
    else if (k == 10) return 9;
    else              return 10;
  endfunction

  function automatic int ua_gate_bit(int u);
    return 30 + u;
  endfunction
endpackage

// File: rtl/otp_cfg_store.sv
module otp_cfg_store
  import otp_guard_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  byte_t               arr_rdata_i,
  input  logic                upd_i,
  input  logic [ADDR_W-1:0]   upd_addr_i,
  input  byte_t               upd_data_i,
  output logic [ADDR_W-1:0]   ld_addr_o,
  output logic                loaded_o,
  output logic [CFG_BITS-1:0] cfg_o
);
  localparam int CNT_W = $clog2(CFG_BYTES + 1);

  logic [CNT_W-1:0] ld_cnt_q;

  assign loaded_o  = (ld_cnt_q == CNT_W'(CFG_BYTES));
  assign ld_addr_o = ADDR_W'(CFG_BASE) + ADDR_W'(ld_cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ld_cnt_q <= '0;
    else if (!loaded_o) ld_cnt_q <= ld_cnt_q + 1'b1;
  end

  for (genvar b = 0; b < CFG_BYTES; b++) begin : g_cfg
    localparam logic [ADDR_W-1:0] BYTE_A = ADDR_W'(CFG_BASE + b);
    byte_t cfg_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        cfg_q <= '0;  // most restrictive until loaded
      else if (!loaded_o && ld_cnt_q == CNT_W'(b))
        cfg_q <= arr_rdata_i;
      else if (upd_i && upd_addr_i == BYTE_A)
        cfg_q <= upd_data_i;
    end
    assign cfg_o[8*b +: 8] = cfg_q;
  end
endmodule

// File: rtl/otp_zone_policy.sv
module otp_zone_policy
  import otp_guard_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                secure_i,
  input  logic                loaded_i,
  input  logic [CFG_BITS-1:0] cfg_i,
  output logic                rd_ok_o,
  output logic                wr_ok_o
);
  logic [NUM_KEYS-1:0]   key_hit, rd_lock, wr_lock;
  logic [NUM_UAREAS-1:0] ua_hit, ua_lock;
  logic                  unused_cfg;

  for (genvar k = 0; k < NUM_KEYS; k++) begin : g_key
    localparam logic [ADDR_W-1:0] FIRST_A = ADDR_W'(key_base(k));
    localparam logic [ADDR_W-1:0] LAST_A  = ADDR_W'(key_base(k) + key_len(k) - 1);
    localparam int RB = key_rd_bit(k);
    localparam int WB = key_wr_bit(k);
    assign key_hit[k] = (addr_i >= FIRST_A) && (addr_i <= LAST_A);
    if (RB == NO_BIT) begin : g_nord
      assign rd_lock[k] = 1'b0;
    end else begin : g_rd
      assign rd_lock[k] = ~cfg_i[RB];
    end
    assign wr_lock[k] = ~cfg_i[WB];
  end

  for (genvar u = 0; u < NUM_UAREAS; u++) begin : g_ua
    localparam logic [ADDR_W-1:0] FIRST_A = ADDR_W'(UA_BASE + u * UA_LEN);
    localparam logic [ADDR_W-1:0] LAST_A  = ADDR_W'(UA_BASE + (u + 1) * UA_LEN - 1);
    assign ua_hit[u]  = (addr_i >= FIRST_A) && (addr_i <= LAST_A);
    assign ua_lock[u] = ~cfg_i[ua_gate_bit(u)] & ~secure_i;
  end

  assign rd_ok_o = loaded_i & ~|(key_hit & rd_lock) & ~|(ua_hit & ua_lock);
  assign wr_ok_o = loaded_i & ~|(key_hit & wr_lock) & ~|(ua_hit & ua_lock);

  assign unused_cfg = ^cfg_i;
endmodule

// File: rtl/otp_key_guard.sv
module otp_key_guard
  import otp_guard_pkg::*;
#(
  parameter int    ADDR_W    = 10,
  parameter byte_t DENY_DATA = 8'hFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              secure_i,
  output logic              rsp_valid_o,
  output logic [7:0]        rsp_rdata_o,
  output logic              err_o,
  output logic [ADDR_W-1:0] arr_addr_o,
  input  logic [7:0]        arr_rdata_i,
  output logic              arr_we_o,
  output logic [7:0]        arr_wdata_o
);
  logic                loaded, rd_ok, wr_ok, rd_go, wr_go, deny;
  logic [ADDR_W-1:0]   ld_addr;
  logic [CFG_BITS-1:0] cfg;

  otp_cfg_store #(.ADDR_W(ADDR_W)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .arr_rdata_i(arr_rdata_i),
    .upd_i      (wr_go),
    .upd_addr_i (addr_i),
    .upd_data_i (arr_wdata_o),
    .ld_addr_o  (ld_addr),
    .loaded_o   (loaded),
    .cfg_o      (cfg)
  );

  otp_zone_policy #(.ADDR_W(ADDR_W)) u_policy (
    .addr_i  (addr_i),
    .secure_i(secure_i),
    .loaded_i(loaded),
    .cfg_i   (cfg),
    .rd_ok_o (rd_ok),
    .wr_ok_o (wr_ok)
  );

  assign rd_go = req_i & ~we_i & rd_ok;
  assign wr_go = req_i &  we_i & wr_ok;
  assign deny  = req_i & ~(rd_go | wr_go);

  // loader owns the array port until the protection bytes are captured
  assign arr_addr_o  = loaded ? addr_i : ld_addr;
  assign arr_we_o    = wr_go;
  assign arr_wdata_o = arr_rdata_i & wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      err_o       <= 1'b0;
      rsp_rdata_o <= DENY_DATA;
    end else begin
      rsp_valid_o <= req_i;
      err_o       <= deny;
      rsp_rdata_o <= rd_go ? arr_rdata_i : DENY_DATA;
    end
  end
endmodule

// File: rtl/otp_key_guard_chk.sv
module otp_key_guard_chk
  import otp_guard_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              rsp_valid_o,
  input logic [7:0]        rsp_rdata_o,
  input logic              err_o,
  input logic [7:0]        arr_rdata_i,
  input logic              arr_we_o,
  input logic [7:0]        arr_wdata_o
);
  localparam int CNT_W = $clog2(CFG_BYTES + 1);
  localparam logic [ADDR_W-1:0] SEC_A = ADDR_W'(SEC_BASE);

  logic [CNT_W-1:0] boot_cnt;
  logic booted;
  assign booted = (boot_cnt == CNT_W'(CFG_BYTES));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      boot_cnt <= '0;
    else if (!booted) boot_cnt <= boot_cnt + 1'b1;
  end

  // R1
  boot_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !booted |-> !arr_we_o);
  // R1
  boot_deny_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!booted && req_i) |=> err_o);
  // R8
  rsp_follows_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> rsp_valid_o);
  // R8
  no_spurious_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !rsp_valid_o);
  // R8
  err_with_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> rsp_valid_o);
  // R2
  deny_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> rsp_rdata_o == 8'hFF);
  // R6
  clear_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_we_o |-> (arr_wdata_o & ~arr_rdata_i) == 8'h00);
  // R3
  dropped_write_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && !arr_we_o) |=> err_o);
  // R3
  granted_write_ok_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && arr_we_o) |=> !err_o);
  // R9
  low_area_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (booted && req_i && addr_i < SEC_A) |=> !err_o);
endmodule

bind otp_key_guard otp_key_guard_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .we_i       (we_i),
  .addr_i     (addr_i),
  .rsp_valid_o(rsp_valid_o),
  .rsp_rdata_o(rsp_rdata_o),
  .err_o      (err_o),
  .arr_rdata_i(arr_rdata_i),
  .arr_we_o   (arr_we_o),
  .arr_wdata_o(arr_wdata_o)
);

// File: tb/otp_key_guard_tb_top.sv
module otp_key_guard_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req = 1'b0, we = 1'b0, sec = 1'b0;
  logic [9:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       rsp_valid, err, arr_we;
  logic [7:0] rsp_rdata, arr_rdata, arr_wdata;
  logic [9:0] arr_addr;

  logic [7:0]  arr_mem [1024];  // array seen by the DUT
  logic [7:0]  ref_mem [1024];  // model image
  logic [31:0] mcfg;
  int          boot_i;
  int          n_chk = 0, n_fail = 0;
  bit          finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  otp_key_guard dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .secure_i(sec), .rsp_valid_o(rsp_valid),
    .rsp_rdata_o(rsp_rdata), .err_o(err), .arr_addr_o(arr_addr),
    .arr_rdata_i(arr_rdata), .arr_we_o(arr_we), .arr_wdata_o(arr_wdata)
  );

  assign arr_rdata = arr_mem[arr_addr];
  always @(posedge clk) if (arr_we) arr_mem[arr_addr] <= arr_wdata;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit m_ok(input bit w, input int a, input bit s);
    int rb, wb, g;
    rb = -1; wb = -1;
    if (boot_i < 4) return 0;
    if (a < 'h200) return 1;
    if (a < 'h300) begin rb = 11 + 2 * ((a - 'h200) / 32); wb = rb + 1; end
    else if (a < 'h310) begin rb = 5; wb = 6; end
    else if (a < 'h320) wb = 7;
    else if (a < 'h340) wb = 9;
    else if (a < 'h360) wb = 10;
    else if (a >= 'h380) begin
      g = (a < 'h3C0) ? 30 : 31;
      return mcfg[g] || s;
    end else return 1;
    if (w) return (wb < 0) || mcfg[wb];
    return (rb < 0) || mcfg[rb];
  endfunction

  // one request cycle: drive at negedge, judge strobe, then response
  task automatic step(input string tag, input bit rq, input bit w,
                      input int a, input logic [7:0] d, input bit s);
    bit booting, ok;
    logic [7:0] old, exp_rd;
    req = rq; we = w; addr = 10'(a); wdata = d; sec = s;
    booting = (boot_i < 4);
    ok = rq && m_ok(w, a, s);
    old = ref_mem[a];
    #2;
    chk(arr_we == (rq && w && ok), {tag, " strobe"}, arr_we, rq && w && ok);
    if (booting)
      chk(arr_addr == 10'('h364 + boot_i), "R1 load addr", arr_addr, 'h364 + boot_i);
    if (rq && w && ok)
      chk(arr_wdata == (old & d), "R6 masked data", arr_wdata, old & d);
    @(posedge clk);
    if (booting) begin
      mcfg[8*boot_i +: 8] = ref_mem['h364 + boot_i];
      boot_i++;
    end else if (rq && w && ok) begin
      ref_mem[a] = old & d;
      if (a >= 'h364 && a <= 'h367) mcfg[8*(a - 'h364) +: 8] = ref_mem[a];
    end
    @(negedge clk);
    exp_rd = (rq && !w && ok) ? old : 8'hFF;
    chk(rsp_valid == rq, {tag, " R8 valid"}, rsp_valid, rq);
    chk(err == (rq && !ok), {tag, " err"}, err, rq && !ok);
    chk(rsp_rdata == exp_rd, {tag, " rdata"}, rsp_rdata, exp_rd);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; req = 1'b0;
    repeat (2) @(negedge clk);
    chk(!rsp_valid && !err && !arr_we, "R8 reset outputs", {rsp_valid, err, arr_we}, 0);
    chk(rsp_rdata == 8'hFF, "R8 reset rdata", rsp_rdata, 'hFF);
    boot_i = 0;
    rst_n = 1'b1;
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) ref_mem[i] = 8'(i * 37 + 11);
    ref_mem['h364] = 8'hFF; ref_mem['h365] = 8'hFF;
    ref_mem['h366] = 8'hFD;  // key 3 read lock pre-programmed
    ref_mem['h367] = 8'hFF;
    for (int i = 0; i < 1024; i++) arr_mem[i] = ref_mem[i];
    mcfg = '0;
    @(negedge clk);
    do_reset();
    // R1: requests during the load are refused; the last load cycle meets a write
    step("R1 boot read", 1, 0, 'h010, 8'h00, 1);
    step("R1 boot sec read", 1, 0, 'h200, 8'h00, 1);
    step("R1 boot idle", 0, 0, 'h000, 8'h00, 0);
    step("R1 boot write", 1, 1, 'h020, 8'h00, 1);
    // R9 / R6: low area passes, only 1->0
    step("R9 low read", 1, 0, 'h010, 8'h00, 0);
    step("R6 low write", 1, 1, 'h010, 8'h0F, 0);
    step("R6 readback", 1, 0, 'h010, 8'h00, 0);
    step("R6 no set", 1, 1, 'h010, 8'hFF, 0);
    step("R6 readback2", 1, 0, 'h010, 8'h00, 0);
    step("R9 cfg area read", 1, 0, 'h36C, 8'h00, 0);
    step("R8 idle", 0, 0, 'h000, 8'h00, 0);
    // R2: boot-time lock on key 3, key 0 open
    step("R2 key3 locked", 1, 0, 'h265, 8'h00, 1);
    step("R2 key0 open", 1, 0, 'h200, 8'h00, 0);
    // R7: lock key 0 read, next cycle refused
    step("R7 lock key0", 1, 1, 'h365, 8'hF7, 0);
    step("R7 key0 next", 1, 0, 'h200, 8'h00, 1);
    step("R10 reopen try", 1, 1, 'h365, 8'hFF, 0);
    step("R10 key0 still", 1, 0, 'h21F, 8'h00, 1);
    // R3: key 1 writable, then write lock
    step("R3 key1 write", 1, 1, 'h220, 8'h00, 0);
    step("R7 lock key1 wr", 1, 1, 'h365, 8'hBF, 0);
    step("R3 key1 dropped", 1, 1, 'h221, 8'h00, 1);
    step("R3 key1 unchanged", 1, 0, 'h221, 8'h00, 0);
    // R4: debug password, unique key, hashes
    step("R4 pwd open", 1, 0, 'h305, 8'h00, 0);
    step("R4 lock pwd", 1, 1, 'h364, 8'h9F, 0);
    step("R4 pwd rd", 1, 0, 'h305, 8'h00, 1);
    step("R4 pwd wr", 1, 1, 'h305, 8'h00, 1);
    step("R4 uniq wr ok", 1, 1, 'h318, 8'hF0, 0);
    step("R4 lock uniq", 1, 1, 'h364, 8'h7F, 0);
    step("R4 uniq wr", 1, 1, 'h318, 8'h00, 0);
    step("R4 uniq rd", 1, 0, 'h318, 8'h00, 0);
    step("R4 lock pk1", 1, 1, 'h365, 8'hFD, 0);
    step("R4 pk1 wr", 1, 1, 'h330, 8'h00, 1);
    step("R4 pk1 rd", 1, 0, 'h330, 8'h00, 0);
    step("R4 pk2 wr", 1, 1, 'h350, 8'h0F, 0);
    // R2 / R3: key 7 in the last protection byte
    step("R2 key7 open", 1, 0, 'h2E5, 8'h00, 0);
    step("R2 lock key7", 1, 1, 'h367, 8'hF9, 0);
    step("R2 key7 rd", 1, 0, 'h2E5, 8'h00, 0);
    step("R3 key7 wr", 1, 1, 'h2E5, 8'h00, 1);
    // R5: user windows
    step("R5 ua1 ns open", 1, 0, 'h390, 8'h00, 0);
    step("R5 gate ua1", 1, 1, 'h367, 8'hBF, 0);
    step("R5 ua1 ns rd", 1, 0, 'h390, 8'h00, 0);
    step("R5 ua1 s rd", 1, 0, 'h390, 8'h00, 1);
    step("R5 ua1 ns wr", 1, 1, 'h3A0, 8'h00, 0);
    step("R5 ua1 s wr", 1, 1, 'h3A0, 8'h0F, 1);
    step("R5 ua2 ns open", 1, 0, 'h3D0, 8'h00, 0);
    step("R5 gate ua2", 1, 1, 'h367, 8'h7F, 0);
    step("R5 ua2 ns rd", 1, 0, 'h3FF, 8'h00, 0);
    step("R5 ua2 s rd", 1, 0, 'h3FF, 8'h00, 1);
    // R10 / R1: reload after reset keeps programmed locks
    @(negedge clk);
    do_reset();
    for (int i = 0; i < 4; i++) step("R1 reload", (i == 0), 0, 'h200, 8'h00, 1);
    step("R10 key0 after reload", 1, 0, 'h200, 8'h00, 1);
    step("R10 ua1 after reload", 1, 0, 'h390, 8'h00, 0);
    step("R9 low after reload", 1, 0, 'h011, 8'h00, 0);
    finished = 1;
    report();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      report();
      $finish;
    end
  end
endmodule